// File: doc/BRIEF.md
# I/O Window Cycle Decoder

This block watches a non-pipelined processor bus and picks out I/O cycles that fall inside one fixed address window. On a clock edge where the active-low address strobe is low, the window bits of the address all read 1, and the type lines mark an I/O data cycle, it sets a registered chip-select enable. The enable then stays set over the following clocks without any further strobe. Ready ends the cycle, a bus timeout cuts it short, and synchronous reset clears it.

While the enable is set, the low device-index bits of the address drive a one-hot select, one line per device in the window. The bus holds the address stable for the whole cycle, so the select decodes the live address bus and the block has no address latch. All decoded selects are zero whenever the enable is clear.

Top module: `iodec_io_window`

## Requirements
- R1: A decode starts only on a clock edge where `ads_n` is 0 and address bits 7, 6 and 5 are all 1. Any other value of those three bits leaves `cs_en` clear.
- R2: A decode also needs `mio` = 0 (I/O space) and `dc` = 1 (data cycle). A memory cycle or a control cycle leaves `cs_en` clear.
- R3: A qualifying cycle sets `cs_en` after the same clock edge that samples it, so `cs_en` is 1 one cycle after the strobe is presented.
- R4: Once set, `cs_en` stays 1 on later edges while `ads_n` is 1, `rdy_n` is 1 and `tmo` is 0.
- R5: An edge that samples `rdy_n` = 0 with no new qualifying strobe clears `cs_en`.
- R6: An edge that samples `tmo` = 1 clears `cs_en`, even when a qualifying strobe is present in that same cycle.
- R7: `rst` is synchronous and active high. An edge that samples it clears `cs_en` and all selects, whatever the other inputs are.
- R8: A qualifying strobe and `rdy_n` = 0 in the same cycle leave `cs_en` at 1. The new cycle wins over the end of the old one.
- R9: While `cs_en` is 1, `dev_sel` has exactly bit k set, where k is the value of address bits 4..2 on the current bus. While `cs_en` is 0, `dev_sel` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe, active low |
| addr | input | ADDR_W-2 (6) | Address bits ADDR_W-1 down to 2 |
| mio | input | 1 | Memory/IO type: 1 memory, 0 I/O |
| dc | input | 1 | Data/control type: 1 data, 0 control |
| rdy_n | input | 1 | Cycle ready, active low |
| tmo | input | 1 | Bus timeout, active high |
| cs_en | output | 1 | Registered chip-select enable |
| dev_sel | output | 2**DEV_BITS (8) | One-hot device select |

## Verification
A new strobe and a ready for the previous cycle can land on the same edge, and so can a strobe and a timeout. The stimulus table builds a back-to-back case: `ads_n` and `rdy_n` both low, with the index bits changed to a new device. The bench expects `cs_en` to stay 1 and `dev_sel` to move to the new device's bit. A second row pairs a qualifying strobe with `tmo`, and there the bench expects `cs_en` to stay 0. The same priorities are also checked as clocked properties inside the top module.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

    // registered state of the decoder
    typedef struct packed {
        logic en;
    } iodec_state_t;

    localparam iodec_state_t IODEC_IDLE = '{en: 1'b0};

endpackage

// File: rtl/iodec_qualify.sv
module iodec_qualify #(
    parameter int WIN_W = 3
) (
    input  logic             ads_n,
    input  logic [WIN_W-1:0] win_bits,
    input  logic             mio,
    input  logic             dc,
    output logic             start
);

    logic in_window;
    logic io_data;

    always_comb begin
        in_window = &win_bits;
        io_data   = !mio && dc;
        start     = !ads_n && in_window && io_data;
    end

endmodule

// File: rtl/iodec_hold.sv
module iodec_hold
    import iodec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rdy_n,
    input  logic tmo,
    output logic en
);

    iodec_state_t st_d;
    iodec_state_t st_q;

    // priority: reset, timeout, new cycle, ready, hold
    always_comb begin
        st_d = st_q;
        if (rst || tmo) begin
            st_d = IODEC_IDLE;
        end else if (start) begin
            st_d.en = 1'b1;
        end else if (!rdy_n) begin
            st_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign en = st_q.en;

    // R6
    tmo_clears_chk: assert property (@(posedge clk) disable iff (rst)
        tmo |=> !en);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && rdy_n && !tmo) |=> en);

endmodule

// File: rtl/iodec_select.sv
module iodec_select #(
    parameter int DEV_BITS = 3,
    localparam int NUM_DEV = 1 << DEV_BITS
) (
    input  logic                en,
    input  logic [DEV_BITS-1:0] idx,
    output logic [NUM_DEV-1:0]  sel
);

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        assign sel[g] = en && (idx == DEV_BITS'(g));
    end

endmodule

// File: rtl/iodec_io_window.sv
module iodec_io_window #(
    parameter int ADDR_W   = 8,
    parameter int WIN_LSB  = 5,
    parameter int DEV_BITS = 3,
    localparam int ALO     = 2,
    localparam int NUM_DEV = 1 << DEV_BITS,
    localparam int WIN_W   = ADDR_W - WIN_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ads_n,
    input  logic [ADDR_W-1:ALO] addr,
    input  logic              mio,
    input  logic              dc,
    input  logic              rdy_n,
    input  logic              tmo,
    output logic              cs_en,
    output logic [NUM_DEV-1:0] dev_sel
);

    logic start_w;
    logic en_w;

    iodec_qualify #(.WIN_W(WIN_W)) i_qualify (
        .ads_n    (ads_n),
        .win_bits (addr[ADDR_W-1:WIN_LSB]),
        .mio      (mio),
        .dc       (dc),
        .start    (start_w)
    );

    iodec_hold i_hold (
        .clk   (clk),
        .rst   (rst),
        .start (start_w),
        .rdy_n (rdy_n),
        .tmo   (tmo),
        .en    (en_w)
    );

    iodec_select #(.DEV_BITS(DEV_BITS)) i_select (
        .en  (en_w),
        .idx (addr[ALO +: DEV_BITS]),
        .sel (dev_sel)
    );

    assign cs_en = en_w;

    // R3
    start_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (start_w && !tmo) |=> cs_en);

    // R5
    ready_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && !start_w) |=> !cs_en);

    // R9
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        cs_en |-> ($countones(dev_sel) == 1));

    // R9
    sel_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_en |-> (dev_sel == '0));

    // R1
    no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_en && (ads_n || !(&addr[ADDR_W-1:WIN_LSB]))) |=> !cs_en);

endmodule

// File: tb/test_iodec_io_window.sv
module test_iodec_io_window;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       ads_n;
        logic [7:0] addr;
        logic       mio;
        logic       dc;
        logic       rdy_n;
        logic       tmo;
        logic       en_exp;
        logic [7:0] sel_exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'hE0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // idle
        '{1'b0, 8'hE4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h02}, // R3 start dev1
        '{1'b1, 8'hE4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h02}, // R4 hold
        '{1'b1, 8'hE4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R5 ready
        '{1'b0, 8'hC8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // R1 outside window
        '{1'b0, 8'hFC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // R2 memory cycle
        '{1'b0, 8'hFC, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R2 control cycle
        '{1'b0, 8'hFC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80}, // R9 dev7
        '{1'b1, 8'hFC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80}, // R4 hold
        '{1'b1, 8'hFC, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}, // R6 timeout
        '{1'b0, 8'hE8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h04}, // R3 start dev2
        '{1'b0, 8'hF0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h10}, // R8 strobe+ready
        '{1'b1, 8'hF0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R5 ready
        '{1'b0, 8'hE0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}, // R6 strobe+timeout
        '{1'b0, 8'hE0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01}, // R9 dev0
        '{1'b1, 8'hEC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h08}  // R9 live address
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       ads_n;
    logic [7:0] abus;
    logic       mio;
    logic       dc;
    logic       rdy_n;
    logic       tmo;
    logic       cs_en;
    logic [7:0] dev_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    iodec_io_window i_iodec_io_window (
        .clk     (clk),
        .rst     (rst),
        .ads_n   (ads_n),
        .addr    (abus[7:2]),
        .mio     (mio),
        .dc      (dc),
        .rdy_n   (rdy_n),
        .tmo     (tmo),
        .cs_en   (cs_en),
        .dev_sel (dev_sel)
    );

    task automatic check(input string req, input logic en_e, input logic [7:0] sel_e);
        n_chk++;
        if (cs_en !== en_e || dev_sel !== sel_e) begin
            n_fail++;
            $display("FAIL %s: cs_en=%b dev_sel=%h expected cs_en=%b dev_sel=%h",
                     req, cs_en, dev_sel, en_e, sel_e);
        end
    endtask

    task automatic drive(input vec_t v);
        ads_n = v.ads_n;
        abus  = v.addr;
        mio   = v.mio;
        dc    = v.dc;
        rdy_n = v.rdy_n;
        tmo   = v.tmo;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        drive(TBL[0]);
        repeat (2) @(posedge clk);
        #1;
        check("R7 reset state", 1'b0, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            @(posedge clk);
            #1;
            check($sformatf("vector %0d", i), TBL[i].en_exp, TBL[i].sel_exp);
        end

        // R7: reset clears an active cycle and beats a fresh strobe
        @(negedge clk);
        drive('{1'b0, 8'hF4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00});
        @(posedge clk);
        #1;
        check("R3 start dev5", 1'b1, 8'h20);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R7 reset with strobe", 1'b0, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        drive('{1'b1, 8'hF4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00});
        @(posedge clk);
        #1;
        check("R7 stays clear after reset", 1'b0, 8'h00);

        // R4: long hold over several idle edges
        @(negedge clk);
        drive('{1'b0, 8'hF8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00});
        @(negedge clk);
        ads_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            #1;
            check("R4 long hold", 1'b1, 8'h40);
        end
        @(negedge clk);
        rdy_n = 1'b0;
        @(posedge clk);
        #1;
        check("R5 ready after hold", 1'b0, 8'h00);

        finish_run();
    end

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule